// File: doc/BRIEF.md
# PWM Trip-Zone Fault Controller

This block sits between a PWM generator and its output pins and forces the outputs to a safe state when a fault is reported. It watches eight active-low fault lines. Software chooses which lines act as cycle-by-cycle faults and which act as one-shot faults. A cycle-by-cycle trip releases by itself at the next PWM period boundary once its selected faults have gone away. A one-shot trip stays in force until software clears it. One trip setting governs every PWM output pair in the block. The override is set once for all A outputs and once for all B outputs.

Fault lines pass through a two-stage synchronizer into the two trip latches. Sticky status flags record each trip class and the individual line that caused it, and these flags drive an interrupt request. A parallel combinational path from the raw fault lines to the output override trips the pins even when the clock has stopped. Software programs the block through a simple write-only register port. The period-boundary strobe and the raw PWM levels come from the PWM counter and the action logic, which lie outside this block.

Register map (write port):

| Address | Contents |
|---|---|
| 0 | Bits [7:0] enable cycle-by-cycle use of each fault line. Bits [15:8] enable one-shot use of the same lines. |
| 1 | Bit 0 enables the cycle-by-cycle interrupt. Bit 1 enables the one-shot interrupt. |
| 2 | Bits [1:0] hold the A-side action. Bits [3:2] hold the B-side action. |
| 3 | Writing 1 to bit 0 clears the cycle-by-cycle flag. Writing 1 to bit 1 releases the one-shot trip and clears its flag. |
| 4 | Writing 1 to a bit clears the matching per-line flag. |

Top module: `tz_trip_ctrl`

## Requirements
- R1: Fault line i is active low. It trips the block only when bit i (cycle-by-cycle) or bit 8+i (one-shot) of address 0 is set. A low level on a line with both bits clear has no effect on the outputs or the flags.
- R2: A low pulse on a selected line that spans 3 rising clock edges is latched. The latch sets on the third rising edge after the line falls, after two synchronizer stages.
- R3: The trip state and each side's action code apply identically to every PWM pair.
- R4: The cycle-by-cycle trip is released at a rising edge where prd_end_i is 1, but only if no selected cycle-by-cycle line is low at the synchronizer output on that edge. Otherwise it stays set.
- R5: The one-shot trip holds through period boundaries. It is released only by writing 1 to bit 1 of address 3.
- R6: cbc_flag_o and ost_flag_o set on a latched event of their class and stay set until cleared by address 3 bit 0 and bit 1 respectively.
- R7: src_flag_o bit i records a cycle-by-cycle event from line i, and bit 8+i records a one-shot event from line i. Each bit clears only when 1 is written to the same bit position at address 4.
- R8: A latched event in the same cycle as a clear write wins. A flag cleared while its fault is still present reads 1 on the next cycle.
- R9: irq_o is 1 when cbc_flag_o is set together with address 1 bit 0, or when ost_flag_o is set together with address 1 bit 1. Otherwise it is 0.
- R10: The behaviour of each side depends on whether the block is tripped and on the side's action code. The A side uses address 2 [1:0] and the B side uses [3:2].
  - Untripped: the output level follows the PWM input and the enable is 1.
  - Code 00 while tripped: the enable is 0 and the level follows the PWM input.
  - Code 01 while tripped: the level is forced to 1.
  - Code 10 while tripped: the level is forced to 0.
  - Code 11 while tripped: the output is left unchanged.
- R11: A selected line that is low trips the outputs combinationally in the same cycle, with no clock edge needed.
- R12: After reset, all selections, enables, flags and trips are 0. The outputs follow the PWM inputs with every enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_ni | input | 8 | Raw fault lines, active low |
| prd_end_i | input | 1 | PWM period-boundary strobe |
| pwm_a_i | input | 4 | Raw A-side PWM levels |
| pwm_b_i | input | 4 | Raw B-side PWM levels |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| pwm_a_o | output | 4 | A-side output levels |
| pwm_a_oe_o | output | 4 | A-side output enables |
| pwm_b_o | output | 4 | B-side output levels |
| pwm_b_oe_o | output | 4 | B-side output enables |
| cbc_flag_o | output | 1 | Sticky cycle-by-cycle event flag |
| ost_flag_o | output | 1 | Sticky one-shot event flag |
| src_flag_o | output | 16 | Sticky per-line event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
Two operations can land on the same clock edge: a latched fault and a software clear of the latch or flag it feeds. Likewise, a period-boundary strobe can coincide with a fault that is still present after synchronization. Directed cases provoke both. A clear write is issued while a fault line is held low, and the strobe is raised on the very edge where the line returns high but the synchronizer still shows it low. In both cases the flag or trip must stay set on the following cycle. Random stimulus then overlaps writes, strobes and fault edges freely. Every cycle is judged against a bench model built from the requirements.

// File: rtl/tz_pkg.sv
package tz_pkg;
  typedef enum logic [1:0] {
    ACT_HIZ  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_KEEP = 2'b11
  } tz_act_e;

  localparam logic [2:0] ADDR_SEL    = 3'd0;
  localparam logic [2:0] ADDR_INTEN  = 3'd1;
  localparam logic [2:0] ADDR_ACT    = 3'd2;
  localparam logic [2:0] ADDR_EVCLR  = 3'd3;
  localparam logic [2:0] ADDR_SRCCLR = 3'd4;
endpackage

// File: rtl/tz_sync.sv
module tz_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  // resets to idle (high) so no fault is seen out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tz_class.sv
module tz_class #(
  parameter int unsigned N_TRIP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIP-1:0] fault_i,
  input  logic [N_TRIP-1:0] sel_i,
  input  logic              rel_i,
  input  logic              flag_clr_i,
  input  logic [N_TRIP-1:0] src_clr_i,
  output logic              hit_o,
  output logic              trip_o,
  output logic              flag_o,
  output logic [N_TRIP-1:0] src_o
);
  logic [N_TRIP-1:0] hits;
  logic              trip_q, flag_q;

  assign hits  = fault_i & sel_i;
  assign hit_o = |hits;

  // a fault present on the same edge wins over release or clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (hit_o)      trip_q <= 1'b1;
      else if (rel_i) trip_q <= 1'b0;
      if (hit_o)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_TRIP; g++) begin : g_src
    logic src_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           src_q <= 1'b0;
      else if (hits[g])      src_q <= 1'b1;
      else if (src_clr_i[g]) src_q <= 1'b0;
    end
    assign src_o[g] = src_q;
  end

  assign trip_o = trip_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tz_out_side.sv
module tz_out_side
  import tz_pkg::*;
#(
  parameter int unsigned N_PAIR = 4
) (
  input  tz_act_e           act_i,
  input  logic              tripped_i,
  input  logic [N_PAIR-1:0] pwm_i,
  output logic [N_PAIR-1:0] lvl_o,
  output logic [N_PAIR-1:0] oe_o
);
  for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
    logic lvl, oe;
    always_comb begin
      lvl = pwm_i[g];
      oe  = 1'b1;
      if (tripped_i) begin
        unique case (act_i)
          ACT_HIZ:  oe  = 1'b0;
          ACT_HIGH: lvl = 1'b1;
          ACT_LOW:  lvl = 1'b0;
          default:  ;
        endcase
      end
    end
    assign lvl_o[g] = lvl;
    assign oe_o[g]  = oe;
  end
endmodule

// File: rtl/tz_trip_ctrl.sv
module tz_trip_ctrl
  import tz_pkg::*;
#(
  parameter  int unsigned N_TRIP = 8,
  parameter  int unsigned N_PAIR = 4,
  localparam int unsigned DW     = 2 * N_TRIP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIP-1:0] trip_ni,
  input  logic              prd_end_i,
  input  logic [N_PAIR-1:0] pwm_a_i,
  input  logic [N_PAIR-1:0] pwm_b_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [N_PAIR-1:0] pwm_a_o,
  output logic [N_PAIR-1:0] pwm_a_oe_o,
  output logic [N_PAIR-1:0] pwm_b_o,
  output logic [N_PAIR-1:0] pwm_b_oe_o,
  output logic              cbc_flag_o,
  output logic              ost_flag_o,
  output logic [DW-1:0]     src_flag_o,
  output logic              irq_o
);
  logic [N_TRIP-1:0] sel_cbc, sel_ost;
  logic [1:0]        int_en;
  tz_act_e           act_a, act_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_cbc <= '0;
      sel_ost <= '0;
      int_en  <= '0;
      act_a   <= ACT_HIZ;
      act_b   <= ACT_HIZ;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_SEL: begin
          sel_cbc <= wr_data_i[N_TRIP-1:0];
          sel_ost <= wr_data_i[DW-1:N_TRIP];
        end
        ADDR_INTEN: int_en <= wr_data_i[1:0];
        ADDR_ACT: begin
          act_a <= tz_act_e'(wr_data_i[1:0]);
          act_b <= tz_act_e'(wr_data_i[3:2]);
        end
        default: ;
      endcase
    end
  end

  logic              ev_clr, clr_cbc, clr_ost;
  logic [DW-1:0]     src_clr;
  assign ev_clr  = wr_en_i && (wr_addr_i == ADDR_EVCLR);
  assign clr_cbc = ev_clr && wr_data_i[0];
  assign clr_ost = ev_clr && wr_data_i[1];
  assign src_clr = (wr_en_i && (wr_addr_i == ADDR_SRCCLR)) ? wr_data_i : '0;

  logic [N_TRIP-1:0] trip_s, fault_s;
  tz_sync #(.WIDTH(N_TRIP)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_ni),
    .q_o   (trip_s)
  );
  assign fault_s = ~trip_s;

  logic cbc_hit, cbc_trip, ost_hit, ost_trip;

  tz_class #(.N_TRIP(N_TRIP)) u_cbc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault_s),
    .sel_i     (sel_cbc),
    .rel_i     (prd_end_i),
    .flag_clr_i(clr_cbc),
    .src_clr_i (src_clr[N_TRIP-1:0]),
    .hit_o     (cbc_hit),
    .trip_o    (cbc_trip),
    .flag_o    (cbc_flag_o),
    .src_o     (src_flag_o[N_TRIP-1:0])
  );

  tz_class #(.N_TRIP(N_TRIP)) u_ost (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault_s),
    .sel_i     (sel_ost),
    .rel_i     (clr_ost),
    .flag_clr_i(clr_ost),
    .src_clr_i (src_clr[DW-1:N_TRIP]),
    .hit_o     (ost_hit),
    .trip_o    (ost_trip),
    .flag_o    (ost_flag_o),
    .src_o     (src_flag_o[DW-1:N_TRIP])
  );

  // clockless path: raw selected lines act on the pins directly
  logic fault_raw, tripped;
  assign fault_raw = |(~trip_ni & (sel_cbc | sel_ost));
  assign tripped   = cbc_trip | ost_trip | fault_raw;

  tz_out_side #(.N_PAIR(N_PAIR)) u_side_a (
    .act_i    (act_a),
    .tripped_i(tripped),
    .pwm_i    (pwm_a_i),
    .lvl_o    (pwm_a_o),
    .oe_o     (pwm_a_oe_o)
  );

  tz_out_side #(.N_PAIR(N_PAIR)) u_side_b (
    .act_i    (act_b),
    .tripped_i(tripped),
    .pwm_i    (pwm_b_i),
    .lvl_o    (pwm_b_o),
    .oe_o     (pwm_b_oe_o)
  );

  assign irq_o = (cbc_flag_o & int_en[0]) | (ost_flag_o & int_en[1]);
endmodule

// File: rtl/tz_trip_ctrl_chk.sv
module tz_trip_ctrl_chk #(
  parameter int unsigned N_TRIP = 8,
  parameter int unsigned N_PAIR = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_TRIP-1:0] trip_ni,
  input logic              prd_end_i,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic [1:0]        wr_lo,
  input logic [N_PAIR-1:0] pwm_a_o,
  input logic [N_PAIR-1:0] pwm_a_oe_o,
  input logic              cbc_flag_o,
  input logic              ost_flag_o,
  input logic              irq_o,
  input logic              cbc_hit,
  input logic              ost_hit,
  input logic              cbc_trip,
  input logic              ost_trip,
  input logic              tripped,
  input logic [N_TRIP-1:0] sel_cbc,
  input logic [N_TRIP-1:0] sel_ost,
  input logic [1:0]        int_en,
  input logic [1:0]        act_a
);
  logic fault_raw;
  assign fault_raw = |(~trip_ni & (sel_cbc | sel_ost));

  a_r4_cbc_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbc_trip && prd_end_i && !cbc_hit |=> !cbc_trip);

  a_r5_ost_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ost_trip && !(wr_en_i && wr_addr_i == 3'd3 && wr_lo[1]) |=> ost_trip);

  a_r6_ost_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ost_hit |=> ost_flag_o && ost_trip);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbc_hit |=> cbc_flag_o && cbc_trip);

  a_r9_irq_cbc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbc_flag_o && int_en[0] |-> irq_o);

  a_r10_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tripped && act_a == 2'b00 |-> pwm_a_oe_o == '0);

  a_r11_raw_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_raw && act_a == 2'b10 |-> pwm_a_o == '0 && pwm_a_oe_o == '1);
endmodule

bind tz_trip_ctrl tz_trip_ctrl_chk #(.N_TRIP(N_TRIP), .N_PAIR(N_PAIR)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trip_ni   (trip_ni),
  .prd_end_i (prd_end_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_lo     (wr_data_i[1:0]),
  .pwm_a_o   (pwm_a_o),
  .pwm_a_oe_o(pwm_a_oe_o),
  .cbc_flag_o(cbc_flag_o),
  .ost_flag_o(ost_flag_o),
  .irq_o     (irq_o),
  .cbc_hit   (cbc_hit),
  .ost_hit   (ost_hit),
  .cbc_trip  (cbc_trip),
  .ost_trip  (ost_trip),
  .tripped   (tripped),
  .sel_cbc   (sel_cbc),
  .sel_ost   (sel_ost),
  .int_en    (int_en),
  .act_a     (act_a)
);

// File: tb/tb_tz_trip_ctrl.sv
module tb_tz_trip_ctrl;
  localparam int NT = 8;
  localparam int NP = 4;

  logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic [NT-1:0]   trip_n = '1;
  logic            prd = 1'b0;
  logic [NP-1:0]   pa = '0, pb = '0;
  logic            wr = 1'b0;
  logic [2:0]      wa = '0;
  logic [2*NT-1:0] wd = '0;
  logic [NP-1:0]   pwm_a_o, pwm_a_oe_o, pwm_b_o, pwm_b_oe_o;
  logic            cbc_flag_o, ost_flag_o, irq_o;
  logic [2*NT-1:0] src_flag_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  tz_trip_ctrl #(.N_TRIP(NT), .N_PAIR(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .trip_ni(trip_n), .prd_end_i(prd),
    .pwm_a_i(pa), .pwm_b_i(pb), .wr_en_i(wr), .wr_addr_i(wa), .wr_data_i(wd),
    .pwm_a_o(pwm_a_o), .pwm_a_oe_o(pwm_a_oe_o), .pwm_b_o(pwm_b_o),
    .pwm_b_oe_o(pwm_b_oe_o), .cbc_flag_o(cbc_flag_o), .ost_flag_o(ost_flag_o),
    .src_flag_o(src_flag_o), .irq_o(irq_o)
  );

  // reference model built from the requirements
  logic [NT-1:0]   m_s1, m_s2, m_selc, m_selo, ch, oh;
  logic [1:0]      m_en, m_acta, m_actb;
  logic            m_ctrip, m_otrip, m_cflag, m_oflag;
  logic [2*NT-1:0] m_src;

  assign ch = ~m_s2 & m_selc;
  assign oh = ~m_s2 & m_selo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_selc <= '0; m_selo <= '0; m_en <= '0;
      m_acta <= '0; m_actb <= '0; m_ctrip <= 0; m_otrip <= 0;
      m_cflag <= 0; m_oflag <= 0; m_src <= '0;
    end else begin
      m_s1 <= trip_n;
      m_s2 <= m_s1;
      if (wr && wa == 3'd0) {m_selo, m_selc} <= wd;
      if (wr && wa == 3'd1) m_en <= wd[1:0];
      if (wr && wa == 3'd2) begin m_acta <= wd[1:0]; m_actb <= wd[3:2]; end
      m_ctrip <= (|ch) ? 1'b1 : (prd ? 1'b0 : m_ctrip);
      m_otrip <= (|oh) ? 1'b1 : ((wr && wa == 3'd3 && wd[1]) ? 1'b0 : m_otrip);
      m_cflag <= (|ch) ? 1'b1 : ((wr && wa == 3'd3 && wd[0]) ? 1'b0 : m_cflag);
      m_oflag <= (|oh) ? 1'b1 : ((wr && wa == 3'd3 && wd[1]) ? 1'b0 : m_oflag);
      for (int i = 0; i < NT; i++) begin
        m_src[i]    <= ch[i] ? 1'b1 : ((wr && wa == 3'd4 && wd[i]) ? 1'b0 : m_src[i]);
        m_src[NT+i] <= oh[i] ? 1'b1 : ((wr && wa == 3'd4 && wd[NT+i]) ? 1'b0 : m_src[NT+i]);
      end
    end
  end

  function automatic logic [NP-1:0] exp_lvl(logic [1:0] act, logic trp, logic [NP-1:0] pwm);
    if (trp && act == 2'b01) return '1;
    if (trp && act == 2'b10) return '0;
    return pwm;
  endfunction

  function automatic logic [NP-1:0] exp_oe(logic [1:0] act, logic trp);
    return (trp && act == 2'b00) ? '0 : '1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic trp;
    trp = m_ctrip | m_otrip | (|(~trip_n & (m_selc | m_selo)));
    chk("R10 pwm_a level", 32'(pwm_a_o), 32'(exp_lvl(m_acta, trp, pa)));
    chk("R10 pwm_a enable", 32'(pwm_a_oe_o), 32'(exp_oe(m_acta, trp)));
    chk("R10 pwm_b level", 32'(pwm_b_o), 32'(exp_lvl(m_actb, trp, pb)));
    chk("R10 pwm_b enable", 32'(pwm_b_oe_o), 32'(exp_oe(m_actb, trp)));
    chk("R6 cbc flag", 32'(cbc_flag_o), 32'(m_cflag));
    chk("R6 ost flag", 32'(ost_flag_o), 32'(m_oflag));
    chk("R7 source flags", 32'(src_flag_o), 32'(m_src));
    chk("R9 irq", 32'(irq_o), 32'((m_cflag & m_en[0]) | (m_oflag & m_en[1])));
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
    compare();
  endtask

  task automatic wr_reg(logic [2:0] a, logic [2*NT-1:0] d);
    wr = 1'b1; wa = a; wd = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic strobe();
    prd = 1'b1;
    tick();
    prd = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_71a3);
    #45 rst_n = 1'b1;
    tick();
    // R12 reset state
    chk("R12 cbc flag", 32'(cbc_flag_o), 0);
    chk("R12 ost flag", 32'(ost_flag_o), 0);
    chk("R12 src flags", 32'(src_flag_o), 0);
    chk("R12 irq", 32'(irq_o), 0);
    chk("R12 enables", 32'(pwm_a_oe_o & pwm_b_oe_o), 32'hf);

    pa = 4'b1010; pb = 4'b0101;
    wr_reg(3'd0, 16'h2004);  // line 2 cycle-by-cycle, line 5 one-shot
    wr_reg(3'd2, 16'h0006);  // A forced low, B forced high
    wr_reg(3'd1, 16'h0001);

    // R1 unselected line
    trip_n[0] = 1'b0;
    repeat (5) tick();
    chk("R1 unselected output", 32'(pwm_a_o), 32'(pa));
    chk("R1 unselected flag", 32'(cbc_flag_o), 0);
    trip_n[0] = 1'b1;

    // R2, R3, R11 three-edge pulse
    trip_n[2] = 1'b0;
    tick();
    chk("R11 raw force A", 32'(pwm_a_o), 0);
    chk("R3 all pairs B", 32'(pwm_b_o), 32'hf);
    tick(); tick();
    trip_n[2] = 1'b1;
    tick();
    chk("R2 pulse latched", 32'(cbc_flag_o), 1);
    chk("R2 source bit", 32'(src_flag_o[2]), 1);
    chk("R9 irq enabled", 32'(irq_o), 1);
    repeat (3) tick();
    chk("R4 held until boundary", 32'(pwm_a_o), 0);
    strobe();
    chk("R4 released at boundary", 32'(pwm_a_o), 32'(pa));
    chk("R6 flag sticky", 32'(cbc_flag_o), 1);

    // R4 boundary with fault still visible after synchronizer
    trip_n[2] = 1'b0;
    repeat (4) tick();
    // R8 clear while fault present
    wr_reg(3'd3, 16'h0001);
    wr_reg(3'd4, 16'h0004);
    chk("R8 flag reasserted", 32'(cbc_flag_o), 1);
    chk("R8 source reasserted", 32'(src_flag_o[2]), 1);
    trip_n[2] = 1'b1;
    strobe();
    chk("R4 stays with fault", 32'(pwm_a_o), 0);
    repeat (3) tick();
    wr_reg(3'd3, 16'h0001);
    wr_reg(3'd4, 16'h0004);
    chk("R6 flag cleared", 32'(cbc_flag_o), 0);
    chk("R7 source cleared", 32'(src_flag_o[2]), 0);
    chk("R9 irq drops", 32'(irq_o), 0);
    strobe();

    // R5 one-shot
    trip_n[5] = 1'b0;
    repeat (3) tick();
    trip_n[5] = 1'b1;
    repeat (3) tick();
    strobe();
    chk("R5 holds over boundary", 32'(pwm_b_o), 32'hf);
    chk("R6 ost flag", 32'(ost_flag_o), 1);
    chk("R7 ost source", 32'(src_flag_o[13]), 1);
    wr_reg(3'd3, 16'h0002);
    chk("R5 released by clear", 32'(pwm_b_o), 32'(pb));
    chk("R7 source independent", 32'(src_flag_o[13]), 1);

    // R10 codes 00 and 11
    wr_reg(3'd2, 16'h0000);
    trip_n[2] = 1'b0;
    tick();
    chk("R10 hiz enable", 32'(pwm_a_oe_o), 0);
    wr_reg(3'd2, 16'h000f);
    chk("R10 keep level", 32'(pwm_a_o), 32'(pa));
    chk("R10 keep enable", 32'(pwm_a_oe_o), 32'hf);
    trip_n[2] = 1'b1;
    repeat (3) tick();
    strobe();
    wr_reg(3'd2, 16'h0006);

    // R11 with clock stopped
    @(negedge clk);
    clk_run = 1'b0;
    #40 trip_n[5] = 1'b0;
    #3;
    chk("R11 stopped clock A", 32'(pwm_a_o), 0);
    chk("R11 stopped clock B", 32'(pwm_b_o), 32'hf);
    #20 trip_n[5] = 1'b1;
    #3;
    chk("R11 follows raw", 32'(pwm_a_o), 32'(pa));
    clk_run = 1'b1;
    tick();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 16 == 0) trip_n[$urandom % NT] ^= 1'b1;
      prd = ($urandom % 12 == 0);
      pa = NP'($urandom); pb = NP'($urandom);
      wr = ($urandom % 8 == 0);
      wa = 3'($urandom % 5);
      wd = 16'($urandom);
      tick();
    end
    wr = 1'b0; prd = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule